// File: doc/BRIEF.md
# Multidrop Address Filter

This block sits between a serial receiver and its receive FIFO on a 9-bit multidrop network. Each received character carries eight data bits and a ninth marker bit. A marker of 1 identifies an address byte. A marker of 0 identifies a data byte. The receiver compares the marker against a forced parity of 0, so every address byte shows up as a parity error. The block decides which characters reach the FIFO. For each written byte it supplies a status bit that goes into the parity-error slot, and it raises a line-status interrupt for address bytes.

In software-assisted mode the block passes every address byte to the host and flags it. Data bytes go through only while a receive-enable flip-flop is set, and the host alone sets or clears that flip-flop. In automatic mode the block compares each address byte with a programmed 8-bit slave address. A match enables reception and stores the address byte. A mismatch disables reception and discards the byte. With multidrop off, every character is stored unfiltered. Outputs are registered: a character accepted on one clock edge appears at the FIFO port after that edge.

Top module: `mdrop_addr_filter`

## Requirements
- R1: After reset, `fifo_wr_o`, `lsr_irq_o` and `rx_en_o` are 0.
- R2: With `mdrop_en_i`=0, every valid character is written. `fifo_flag_o` equals its marker, and `rx_en_o` is forced to 0. When `mdrop_en_i`=0, this clearing takes priority over a host set.
- R3: In software-assisted mode (`mdrop_en_i`=1, `auto_mode_i`=0), an address byte (marker 1) is always written with `fifo_flag_o`=1. The byte does not change `rx_en_o`.
- R4: In software-assisted mode, a data byte (marker 0) is written with `fifo_flag_o`=0 only while `rx_en_o`=1. Otherwise it is dropped.
- R5: In automatic mode (`auto_mode_i`=1), an address byte equal to `slave_addr_i` is written with `fifo_flag_o`=1 and sets `rx_en_o`. This holds whether `rx_en_o` was 0 or 1 before the byte.
- R6: In automatic mode, an address byte not equal to `slave_addr_i` is not written and clears `rx_en_o`.
- R7: In automatic mode, a data byte is written with `fifo_flag_o`=0 only while `rx_en_o`=1.
- R8: `lsr_irq_o` is a one-cycle pulse. It is high exactly when `fifo_wr_o` and `fifo_flag_o` are both high. `fifo_data_o` carries the character's eight data bits.
- R9: `rx_en_clr_i` sets `rx_en_o` to 0. `rx_en_set_i` sets `rx_en_o` to 1. If both are high in the same cycle, the clear wins. Either host write takes priority over any change that a character in the same cycle would make.
- R10: A character accepted on a rising edge drives `fifo_wr_o` in the following cycle. `fifo_wr_o` is never high unless `rx_valid_i` was high on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdrop_en_i | input | 1 | Multidrop operation enable |
| auto_mode_i | input | 1 | 1 = automatic address match, 0 = software-assisted |
| slave_addr_i | input | 8 | Programmed slave address |
| rx_en_set_i | input | 1 | Host write that sets the receive enable |
| rx_en_clr_i | input | 1 | Host write that clears the receive enable |
| rx_valid_i | input | 1 | Character-valid strobe from the receiver |
| rx_data_i | input | 8 | Received data bits |
| rx_mark_i | input | 1 | Ninth (marker) bit |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | Byte to store |
| fifo_flag_o | output | 1 | Parity-error status stored with the byte |
| lsr_irq_o | output | 1 | Line-status interrupt pulse |
| rx_en_o | output | 1 | Receive-enable state |

## Verification
A single stimulus sequence runs data bytes, matching addresses and non-matching addresses in both modes, with the enable state carried over from one character to the next. This shows that the result depends on the mode and on the prior enable state, and not only on the current character. In automatic mode, a mismatch is sent while the receiver is enabled and a match is sent while it is already enabled. These cases separate a filter that merely compares addresses from one that also tracks the enable state. Directed cases then apply simultaneous host set and clear, a host clear in the same cycle as a matching address, and a change of multidrop mode. These cases pin down the priority order.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  parameter int unsigned DATA_W = 8;

  typedef enum logic [1:0] {
    K_DATA     = 2'd0,
    K_ADDR_HIT = 2'd1,
    K_ADDR_MIS = 2'd2
  } kind_e;

  typedef struct packed {
    logic wr;
    logic flag;
    logic upd;   // character changes enable state
    logic val;   // new enable value when upd
  } act_t;
endpackage

// File: rtl/mdrop_classify.sv
module mdrop_classify
  import mdrop_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] data_i,
  input  logic         mark_i,
  input  logic [W-1:0] addr_i,
  output kind_e        kind_o
);
  always_comb begin
    if (!mark_i)             kind_o = K_DATA;
    else if (data_i == addr_i) kind_o = K_ADDR_HIT;
    else                     kind_o = K_ADDR_MIS;
  end
endmodule

// File: rtl/mdrop_decide.sv
module mdrop_decide
  import mdrop_pkg::*;
(
  input  logic  valid_i,
  input  logic  mdrop_i,
  input  logic  auto_i,
  input  logic  en_i,
  input  logic  mark_i,
  input  kind_e kind_i,
  output act_t  act_o
);
  always_comb begin
    act_o = '0;
    if (valid_i) begin
      if (!mdrop_i) begin
        act_o.wr   = 1'b1;
        act_o.flag = mark_i;
      end else if (!auto_i) begin
        act_o.wr   = mark_i | en_i;
        act_o.flag = mark_i;
      end else begin
        unique case (kind_i)
          K_ADDR_HIT: begin
            act_o.wr   = 1'b1;
            act_o.flag = 1'b1;
            act_o.upd  = 1'b1;
            act_o.val  = 1'b1;
          end
          K_ADDR_MIS: begin
            act_o.upd  = 1'b1;
            act_o.val  = 1'b0;
          end
          default: act_o.wr = en_i;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdrop_en_ctl.sv
module mdrop_en_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mdrop_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic upd_i,
  input  logic val_i,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= 1'b0;
    else if (!mdrop_i) en_o <= 1'b0;
    else if (clr_i)   en_o <= 1'b0;
    else if (set_i)   en_o <= 1'b1;
    else if (upd_i)   en_o <= val_i;
  end
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
  import mdrop_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mdrop_en_i,
  input  logic              auto_mode_i,
  input  logic [DATA_W-1:0] slave_addr_i,
  input  logic              rx_en_set_i,
  input  logic              rx_en_clr_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_mark_i,
  output logic              fifo_wr_o,
  output logic [DATA_W-1:0] fifo_data_o,
  output logic              fifo_flag_o,
  output logic              lsr_irq_o,
  output logic              rx_en_o
);
  kind_e kind;
  act_t  act;

  mdrop_classify #(.W(DATA_W)) u_cls (
    .data_i (rx_data_i),
    .mark_i (rx_mark_i),
    .addr_i (slave_addr_i),
    .kind_o (kind)
  );

  mdrop_decide u_dec (
    .valid_i (rx_valid_i),
    .mdrop_i (mdrop_en_i),
    .auto_i  (auto_mode_i),
    .en_i    (rx_en_o),
    .mark_i  (rx_mark_i),
    .kind_i  (kind),
    .act_o   (act)
  );

  mdrop_en_ctl u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mdrop_i (mdrop_en_i),
    .set_i   (rx_en_set_i),
    .clr_i   (rx_en_clr_i),
    .upd_i   (act.upd),
    .val_i   (act.val),
    .en_o    (rx_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_wr_o   <= 1'b0;
      fifo_flag_o <= 1'b0;
      lsr_irq_o   <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      fifo_wr_o   <= act.wr;
      fifo_flag_o <= act.wr & act.flag;
      lsr_irq_o   <= act.wr & act.flag;
      if (act.wr) fifo_data_o <= rx_data_i;
    end
  end
endmodule

// File: rtl/mdrop_addr_filter_chk.sv
module mdrop_addr_filter_chk
  import mdrop_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mdrop_en_i,
  input logic              auto_mode_i,
  input logic [DATA_W-1:0] slave_addr_i,
  input logic              rx_en_set_i,
  input logic              rx_en_clr_i,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              rx_mark_i,
  input logic              fifo_wr_o,
  input logic              fifo_flag_o,
  input logic              lsr_irq_o,
  input logic              rx_en_o
);
  assert_irq_with_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_irq_o |-> (fifo_wr_o && fifo_flag_o));

  assert_write_needs_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> $past(rx_valid_i));

  assert_off_clears_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mdrop_en_i |=> !rx_en_o);

  assert_clr_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_clr_i |=> !rx_en_o);

  assert_auto_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mdrop_en_i && auto_mode_i && rx_mark_i &&
     rx_data_i != slave_addr_i && !rx_en_set_i) |=> (!fifo_wr_o && !rx_en_o));

  assert_auto_hit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mdrop_en_i && auto_mode_i && rx_mark_i &&
     rx_data_i == slave_addr_i && !rx_en_clr_i) |=> (fifo_wr_o && fifo_flag_o && rx_en_o));

  assert_sw_addr_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mdrop_en_i && !auto_mode_i && rx_mark_i) |=> (fifo_wr_o && fifo_flag_o));
endmodule

bind mdrop_addr_filter mdrop_addr_filter_chk u_chk (.*);

// File: tb/tb_mdrop_addr_filter.sv
module tb_mdrop_addr_filter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mdrop_en_i = 1'b0, auto_mode_i = 1'b0;
  logic [7:0] slave_addr_i = 8'h5A;
  logic       rx_en_set_i = 1'b0, rx_en_clr_i = 1'b0;
  logic       rx_valid_i = 1'b0, rx_mark_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       fifo_wr_o, fifo_flag_o, lsr_irq_o, rx_en_o;
  logic [7:0] fifo_data_o;
  int errors = 0, checks = 0;

  always #2.5 clk_i = ~clk_i;

  mdrop_addr_filter dut (.*);

  typedef struct packed {
    logic md, au, st, cl, vl, mk;
    logic [7:0] d;
    logic ew, ef, ee;
  } vec_t;

  // slave address 0x5A; state carries from row to row
  localparam vec_t VEC [17] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h11, 1'b0,1'b0,1'b0}, // R4 data dropped, disabled
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h22, 1'b1,1'b1,1'b0}, // R3 addr kept, en unchanged
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1}, // R9 host set
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,8'h33, 1'b1,1'b0,1'b1}, // R4 data passes
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,8'h44, 1'b1,1'b1,1'b1}, // R3 addr, en stays
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0}, // R9 host clear
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h55, 1'b0,1'b0,1'b0}, // R7 data dropped
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,8'h12, 1'b0,1'b0,1'b0}, // R6 miss while off
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,8'h5A, 1'b1,1'b1,1'b1}, // R5 hit enables
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h66, 1'b1,1'b0,1'b1}, // R7 data passes
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,8'h5A, 1'b1,1'b1,1'b1}, // R5 hit while on
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,8'h13, 1'b0,1'b0,1'b0}, // R6 miss disables
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,8'h77, 1'b0,1'b0,1'b0}, // R7 dropped again
    '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1,8'h5A, 1'b1,1'b1,1'b1}, // R5 re-enable
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0}, // R2 off clears en
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h88, 1'b1,1'b0,1'b0}, // R2 raw data
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,8'h99, 1'b1,1'b1,1'b0}  // R2 raw marked
  };

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk_i);
    mdrop_en_i = v.md; auto_mode_i = v.au;
    rx_en_set_i = v.st; rx_en_clr_i = v.cl;
    rx_valid_i = v.vl; rx_mark_i = v.mk; rx_data_i = v.d;
    @(negedge clk_i);
    rx_en_set_i = 1'b0; rx_en_clr_i = 1'b0; rx_valid_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic ew, input logic ef, input logic ee, input logic [7:0] d);
    chk(req, "wr", {7'd0, fifo_wr_o}, {7'd0, ew});
    chk(req, "irq R8", {7'd0, lsr_irq_o}, {7'd0, ew & ef});
    chk(req, "en", {7'd0, rx_en_o}, {7'd0, ee});
    if (ew) begin
      chk(req, "flag", {7'd0, fifo_flag_o}, {7'd0, ef});
      chk(req, "data R8", fifo_data_o, d);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    expect_out("R1", 1'b0, 1'b0, 1'b0, 8'h00);
    rst_ni = 1'b1;

    for (int i = 0; i < 17; i++) begin
      apply(VEC[i]);
      expect_out($sformatf("table row %0d", i), VEC[i].ew, VEC[i].ef, VEC[i].ee, VEC[i].d);
    end

    // R9: set and clear together, clear wins
    apply('{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1});
    apply('{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0});
    expect_out("R9 set+clr", 1'b0, 1'b0, 1'b0, 8'h00);

    // R9: host clear beats matching address; byte still written (R5)
    apply('{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1,8'h5A, 1'b0,1'b0,1'b0});
    expect_out("R9 clr vs hit", 1'b1, 1'b1, 1'b0, 8'h5A);

    // R9: host set beats mismatching address; byte dropped (R6)
    apply('{1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,8'h21, 1'b0,1'b0,1'b0});
    expect_out("R9 set vs miss", 1'b0, 1'b0, 1'b1, 8'h00);

    // R2: off beats host set
    apply('{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0});
    expect_out("R2 off vs set", 1'b0, 1'b0, 1'b0, 8'h00);

    // R10: idle cycle, no write
    @(negedge clk_i);
    expect_out("R10 idle", 1'b0, 1'b0, 1'b0, 8'h00);

    // R1: reset in flight
    mdrop_en_i = 1'b1;
    apply('{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1});
    rx_valid_i = 1'b1; rx_mark_i = 1'b1; rx_data_i = 8'hAB;
    @(posedge clk_i);
    #1 rst_ni = 1'b0; rx_valid_i = 1'b0;
    @(negedge clk_i);
    expect_out("R1 mid reset", 1'b0, 1'b0, 1'b0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule